// File: doc/BRIEF.md
# Byte-Splittable Register File

This block holds the working registers of a small 16-bit datapath: eight word registers. Four of them are data registers (accumulator, count, data, base), and four are pointer and index registers (stack pointer, frame pointer, source index, destination index). Each data register can also be addressed as two independent 8-bit halves. A write to one half never disturbs the other half. The pointer and index registers are word-only.

There are two combinational read ports and one synchronous write port. Every port carries a 3-bit register index and a byte-mode select. In word mode the index names one of the eight registers directly. In byte mode, index bit 2 is the half select (0 = bits 7..0, 1 = bits 15..8) and index bits 1..0 name the data register. Because of this encoding, a byte access can only name a data register.

A separate loop-decrement request subtracts one from the count register. One cycle later, the block reports whether the new count is zero (loop exit) or not (loop continues).

Top module: `splitreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to 0x0000 and clears `loop_valid` and `loop_exit`.
- R2: A word-mode write (`wr_byte`=0) stores all 16 bits of `wr_data` into the register named by `wr_idx`. The word indices are 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 frame pointer, 6 source index and 7 destination index. The new value is readable in the cycle after the write edge. A value narrower than 16 bits is supplied right-aligned with zero upper bits, and it is stored unchanged.
- R3: A byte-mode write with `wr_idx[2]`=0 stores `wr_data[7:0]` into bits 7..0 of data register `wr_idx[1:0]`. Bits 15..8 of that register keep their value.
- R4: A byte-mode write with `wr_idx[2]`=1 stores `wr_data[7:0]` into bits 15..8 of data register `wr_idx[1:0]`. Bits 7..0 keep their value, and `wr_data[15:8]` is ignored.
- R5: A word-mode read returns the full 16-bit content of the named register combinationally, in the same cycle as the index is applied, on either read port.
- R6: A byte-mode read returns the selected half of data register `idx[1:0]`, zero-extended to 16 bits. Bit 2 of the index selects the high half.
- R7: A read that names the register being written in the same cycle returns the value held before that write. The two read ports work independently of each other.
- R8: When `loop_dec` is high at an edge, the count register (word index 1) becomes its old value minus one, modulo 2^16. In the following cycle `loop_valid` is 1, and `loop_exit` is 1 exactly when the new count is zero. When no decrement was requested, both flags are 0.
- R9: If `loop_dec` coincides with a write that targets the count register, the decrement wins and the write is dropped. Such a write is a word write to index 1, a byte write to index 1 (low half) or a byte write to index 5 (high half).
- R10: With `wr_en`=0 and `loop_dec`=0, no register changes, whatever `wr_data`, `wr_idx` and `wr_byte` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write size: 0 word, 1 byte |
| wr_idx | input | 3 | Write register index (byte mode: bit 2 half, bits 1..0 data register) |
| wr_data | input | 16 | Write data (byte mode uses bits 7..0) |
| loop_dec | input | 1 | Decrement count register and test for zero |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_byte | input | 1 | Read port 0 size: 0 word, 1 byte |
| rd0_data | output | 16 | Read port 0 data |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_byte | input | 1 | Read port 1 size: 0 word, 1 byte |
| rd1_data | output | 16 | Read port 1 data |
| loop_valid | output | 1 | A decrement took effect at the last edge |
| loop_exit | output | 1 | The decremented count is zero |

## Verification
Read data is due in the same cycle as its index, with no register on the path. Every read is therefore compared shortly after the inputs are applied, against the register contents as they stood before that cycle's edge.

A write changes read results only from the next cycle. The bench model applies each write after it has computed that cycle's expected reads.

The loop flags pass through one register. Their expected values are pushed to the scoreboard one cycle after the decrement request, and they are compared in that later cycle.

// File: rtl/splitreg_pkg.sv
package splitreg_pkg;

    typedef enum logic [2:0] {
        RG_ACC = 3'd0,
        RG_CNT = 3'd1,
        RG_DAT = 3'd2,
        RG_BAS = 3'd3,
        RG_STK = 3'd4,
        RG_FRM = 3'd5,
        RG_SRC = 3'd6,
        RG_DST = 3'd7
    } reg_id_e;

endpackage

// File: rtl/splitreg_wdec.sv
module splitreg_wdec #(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic                     en,
    input  logic                     byte_mode,
    input  logic [$clog2(NREG)-1:0]  idx,
    input  logic [DW-1:0]            data,
    output logic [NREG-1:0]          lo_we,
    output logic [NREG-1:0]          hi_we,
    output logic [DW/2-1:0]          lo_val,
    output logic [DW/2-1:0]          hi_val
);
    localparam int IDXW  = $clog2(NREG);
    localparam int HW    = DW / 2;
    localparam int NDATA = NREG / 2;

    logic             half_sel;
    logic [IDXW-2:0]  data_sel;

    assign half_sel = idx[IDXW-1];
    assign data_sel = idx[IDXW-2:0];

    // In byte mode both halves take the low byte of the write data.
    assign lo_val = data[HW-1:0];
    assign hi_val = byte_mode ? data[HW-1:0] : data[DW-1:HW];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i < NDATA) begin : g_split
            assign lo_we[i] = en & (byte_mode
                ? (!half_sel && data_sel == (IDXW-1)'(i))
                : (idx == IDXW'(i)));
            assign hi_we[i] = en & (byte_mode
                ? (half_sel && data_sel == (IDXW-1)'(i))
                : (idx == IDXW'(i)));
        end else begin : g_word
            assign lo_we[i] = en & !byte_mode & (idx == IDXW'(i));
            assign hi_we[i] = en & !byte_mode & (idx == IDXW'(i));
        end
    end

endmodule

// File: rtl/splitreg_rport.sv
module splitreg_rport #(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic [NREG-1:0][DW-1:0]  regs,
    input  logic [$clog2(NREG)-1:0]  idx,
    input  logic                     byte_mode,
    output logic [DW-1:0]            data
);
    localparam int IDXW = $clog2(NREG);
    localparam int HW   = DW / 2;

    logic [DW-1:0] word_sel;
    logic [DW-1:0] half_src;
    logic [HW-1:0] half_val;

    assign word_sel = regs[idx];
    assign half_src = regs[{1'b0, idx[IDXW-2:0]}];
    assign half_val = idx[IDXW-1] ? half_src[DW-1:HW] : half_src[HW-1:0];
    assign data     = byte_mode ? {{HW{1'b0}}, half_val} : word_sel;

endmodule

// File: rtl/splitreg_file.sv
module splitreg_file
    import splitreg_pkg::*;
#(
    parameter int DW      = 16,
    parameter int NREG    = 8,
    parameter int CNT_IDX = int'(RG_CNT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_byte,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     loop_dec,
    input  logic [$clog2(NREG)-1:0]  rd0_idx,
    input  logic                     rd0_byte,
    output logic [DW-1:0]            rd0_data,
    input  logic [$clog2(NREG)-1:0]  rd1_idx,
    input  logic                     rd1_byte,
    output logic [DW-1:0]            rd1_data,
    output logic                     loop_valid,
    output logic                     loop_exit
);
    localparam int IDXW   = $clog2(NREG);
    localparam int HW     = DW / 2;
    localparam int NRPORT = 2;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] rf;
        logic                    lv;
        logic                    lz;
    } st_t;

    st_t st_d, st_q;

    logic [NREG-1:0] lo_we, hi_we;
    logic [HW-1:0]   lo_val, hi_val;
    logic [DW-1:0]   cnt_dec;
    logic [NREG-1:0][DW-1:0] rf_q;

    logic [NRPORT-1:0][IDXW-1:0] rp_idx;
    logic [NRPORT-1:0]           rp_byte;
    logic [NRPORT-1:0][DW-1:0]   rp_data;

    splitreg_wdec #(.DW(DW), .NREG(NREG)) u_wdec (
        .en        (wr_en),
        .byte_mode (wr_byte),
        .idx       (wr_idx),
        .data      (wr_data),
        .lo_we     (lo_we),
        .hi_we     (hi_we),
        .lo_val    (lo_val),
        .hi_val    (hi_val)
    );

    assign rf_q     = st_q.rf;
    assign cnt_dec  = st_q.rf[CNT_IDX] - DW'(1);

    assign rp_idx[0]  = rd0_idx;
    assign rp_byte[0] = rd0_byte;
    assign rp_idx[1]  = rd1_idx;
    assign rp_byte[1] = rd1_byte;

    for (genvar p = 0; p < NRPORT; p++) begin : g_rport
        splitreg_rport #(.DW(DW), .NREG(NREG)) u_rport (
            .regs      (rf_q),
            .idx       (rp_idx[p]),
            .byte_mode (rp_byte[p]),
            .data      (rp_data[p])
        );
    end

    assign rd0_data   = rp_data[0];
    assign rd1_data   = rp_data[1];
    assign loop_valid = st_q.lv;
    assign loop_exit  = st_q.lz;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            // The loop decrement owns the count register in its cycle.
            if (!(loop_dec && i == CNT_IDX)) begin
                if (lo_we[i]) st_d.rf[i][HW-1:0]  = lo_val;
                if (hi_we[i]) st_d.rf[i][DW-1:HW] = hi_val;
            end
        end
        st_d.lv = loop_dec;
        st_d.lz = 1'b0;
        if (loop_dec) begin
            st_d.rf[CNT_IDX] = cnt_dec;
            st_d.lz          = (cnt_dec == '0);
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/splitreg_chk.sv
module splitreg_chk #(
    parameter int DW      = 16,
    parameter int NREG    = 8,
    parameter int CNT_IDX = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_byte,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     loop_dec,
    input  logic [$clog2(NREG)-1:0]  rd0_idx,
    input  logic                     rd0_byte,
    input  logic [DW-1:0]            rd0_data,
    input  logic [NREG-1:0][DW-1:0]  rf,
    input  logic                     loop_valid,
    input  logic                     loop_exit
);
    localparam int IDXW = $clog2(NREG);
    localparam int HW   = DW / 2;
    localparam logic [IDXW-1:0] CNT_SEL = IDXW'(CNT_IDX);

    logic [IDXW-2:0] dsel;
    logic            hit_cnt;

    assign dsel    = wr_idx[IDXW-2:0];
    assign hit_cnt = loop_dec && (wr_byte ? (dsel == CNT_SEL[IDXW-2:0])
                                          : (wr_idx == CNT_SEL));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rf == '0) && !loop_valid && !loop_exit);

    assert_word_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_byte && !hit_cnt) |=> rf[$past(wr_idx)] == $past(wr_data));

    assert_low_keeps_high_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && !wr_idx[IDXW-1] && !hit_cnt)
        |=> rf[{1'b0, $past(dsel)}] ==
            {$past(rf[{1'b0, dsel}][DW-1:HW]), $past(wr_data[HW-1:0])});

    assert_high_keeps_low_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && wr_idx[IDXW-1] && !hit_cnt)
        |=> rf[{1'b0, $past(dsel)}] ==
            {$past(wr_data[HW-1:0]), $past(rf[{1'b0, dsel}][HW-1:0])});

    assert_word_read_R5: assert property (@(posedge clk) disable iff (rst)
        !rd0_byte |-> rd0_data == rf[rd0_idx]);

    assert_loop_flags_R8: assert property (@(posedge clk) disable iff (rst)
        loop_dec |=> loop_valid && (loop_exit == (rf[CNT_IDX] == '0)));

    assert_loop_wins_R9: assert property (@(posedge clk) disable iff (rst)
        loop_dec |=> rf[CNT_IDX] == $past(rf[CNT_IDX]) - DW'(1));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !loop_dec) |=> rf == $past(rf));

endmodule

bind splitreg_file splitreg_chk #(.DW(DW), .NREG(NREG), .CNT_IDX(CNT_IDX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_byte    (wr_byte),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .loop_dec   (loop_dec),
    .rd0_idx    (rd0_idx),
    .rd0_byte   (rd0_byte),
    .rd0_data   (rd0_data),
    .rf         (rf_q),
    .loop_valid (loop_valid),
    .loop_exit  (loop_exit)
);

// File: tb/splitreg_file_tb.sv
`timescale 1ns/1ps
module splitreg_file_tb;
    import splitreg_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_byte, loop_dec;
    logic [2:0]  wr_idx, rd0_idx, rd1_idx;
    logic [15:0] wr_data;
    logic        rd0_byte, rd1_byte;
    logic [15:0] rd0_data, rd1_data;
    logic        loop_valid, loop_exit;

    always #2 clk = ~clk;

    splitreg_file u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
        .wr_idx(wr_idx), .wr_data(wr_data), .loop_dec(loop_dec),
        .rd0_idx(rd0_idx), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_byte(rd1_byte), .rd1_data(rd1_data),
        .loop_valid(loop_valid), .loop_exit(loop_exit)
    );

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [15:0] m [8];
    logic        exp_lv, exp_lz;
    string       prev_tag;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 0;

    function automatic logic [15:0] model_rd(logic [2:0] i, logic b);
        logic [15:0] w;
        if (!b) return m[i];
        w = m[{1'b0, i[1:0]}];
        return i[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic push(int k, logic [15:0] e, string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic zero_model();
        for (int i = 0; i < 8; i++) m[i] = 16'h0000;
        exp_lv = 1'b0; exp_lz = 1'b0;
        prev_tag = "R1";
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_byte = 1'b0; wr_idx = 3'd2;
        wr_data = 16'hDEAD; loop_dec = 1'b1;
        rd0_idx = 3'd0; rd0_byte = 1'b0; rd1_idx = 3'd1; rd1_byte = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; loop_dec = 1'b0;
        zero_model();
    endtask

    // One cycle: expected reads use the contents before this edge.
    task automatic cyc(logic we, logic wb, logic [2:0] wi, logic [15:0] wd,
                       logic ld, logic [2:0] r0i, logic r0b,
                       logic [2:0] r1i, logic r1b, string tag);
        logic clash;
        @(negedge clk);
        push(2, {15'h0, exp_lv}, prev_tag);
        push(3, {15'h0, exp_lz}, prev_tag);
        wr_en = we; wr_byte = wb; wr_idx = wi; wr_data = wd; loop_dec = ld;
        rd0_idx = r0i; rd0_byte = r0b; rd1_idx = r1i; rd1_byte = r1b;
        push(0, model_rd(r0i, r0b), tag);
        push(1, model_rd(r1i, r1b), tag);
        clash = ld && (wb ? (wi[1:0] == 2'd1) : (wi == 3'd1));
        if (we && !clash) begin
            if (wb) begin
                if (wi[2]) m[{1'b0, wi[1:0]}][15:8] = wd[7:0];
                else       m[{1'b0, wi[1:0]}][7:0]  = wd[7:0];
            end else begin
                m[wi] = wd;
            end
        end
        if (ld) begin
            m[1]   = m[1] - 16'd1;
            exp_lv = 1'b1;
            exp_lz = (m[1] == 16'h0000);
        end else begin
            exp_lv = 1'b0;
            exp_lz = 1'b0;
        end
        prev_tag = tag;
    endtask

    task automatic rd_pair(logic [2:0] a, logic ab, logic [2:0] b, logic bb, string tag);
        cyc(1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, a, ab, b, bb, tag);
    endtask

    // Monitor: compares every queued item of this cycle.
    always begin
        item_t       it;
        logic [15:0] act;
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.kind)
                0:       act = rd0_data;
                1:       act = rd1_data;
                2:       act = {15'h0, loop_valid};
                default: act = {15'h0, loop_exit};
            endcase
            vectors++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s item %0d: actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b0; wr_en = 1'b0; wr_byte = 1'b0; wr_idx = 3'd0; wr_data = 16'h0;
        loop_dec = 1'b0; rd0_idx = 3'd0; rd0_byte = 1'b0; rd1_idx = 3'd0; rd1_byte = 1'b0;
        zero_model();
        do_reset();
        // R1: all registers read zero after reset
        for (int i = 0; i < 8; i += 2) rd_pair(3'(i), 1'b0, 3'(i + 1), 1'b0, "R1");

        // R2 / R7: word writes, reading the written register in the same cycle
        for (int i = 0; i < 8; i++)
            cyc(1'b1, 1'b0, 3'(i), 16'h1000 * 16'(i + 1) + 16'h0A5 + 16'(i), 1'b0,
                3'(i), 1'b0, 3'((i + 3) % 8), 1'b0, "R7");
        cyc(1'b1, 1'b0, 3'd6, 16'h0013, 1'b0, 3'd6, 1'b0, 3'd6, 1'b1, "R2");
        // R5: full word readback on both ports
        for (int i = 0; i < 8; i++) rd_pair(3'(i), 1'b0, 3'(7 - i), 1'b0, "R5");

        // R3: low-half byte writes keep the high half
        for (int i = 0; i < 4; i++)
            cyc(1'b1, 1'b1, 3'(i), 16'hFF00 | 16'(8'h31 + i), 1'b0, 3'(i), 1'b0, 3'(i), 1'b1, "R3");
        for (int i = 0; i < 4; i++) rd_pair(3'(i), 1'b0, 3'(i), 1'b1, "R3");
        // R4: high-half byte writes keep the low half, upper data ignored
        for (int i = 0; i < 4; i++)
            cyc(1'b1, 1'b1, 3'(i + 4), 16'hEE00 | 16'(8'hC0 + i), 1'b0, 3'(i + 4), 1'b1, 3'(i), 1'b0, "R4");
        for (int i = 0; i < 4; i++) rd_pair(3'(i), 1'b0, 3'(i + 4), 1'b1, "R4");
        // R6: byte reads zero-extended, both halves on both ports
        for (int i = 0; i < 8; i++) rd_pair(3'(i), 1'b1, 3'(7 - i), 1'b1, "R6");

        // R10: idle cycles with active-looking data change nothing
        cyc(1'b0, 1'b0, 3'd4, 16'hBEEF, 1'b0, 3'd4, 1'b0, 3'd0, 1'b0, "R10");
        cyc(1'b0, 1'b1, 3'd5, 16'h5A5A, 1'b0, 3'd1, 1'b1, 3'd5, 1'b1, "R10");
        rd_pair(3'd4, 1'b0, 3'd1, 1'b0, "R10");

        // R8: count 3 down to zero, then wrap
        cyc(1'b1, 1'b0, 3'd1, 16'h0003, 1'b0, 3'd1, 1'b0, 3'd0, 1'b0, "R8");
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 3'd1, 1'b0, 3'd2, 1'b0, "R8");
        rd_pair(3'd1, 1'b0, 3'd5, 1'b1, "R8");
        cyc(1'b1, 1'b0, 3'd1, 16'h0001, 1'b0, 3'd1, 1'b0, 3'd1, 1'b0, "R8");
        cyc(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 3'd1, 1'b0, 3'd1, 1'b1, "R8");
        rd_pair(3'd1, 1'b0, 3'd0, 1'b0, "R8");

        // R9: decrement beats a write to the count register
        cyc(1'b1, 1'b0, 3'd1, 16'h0100, 1'b0, 3'd1, 1'b0, 3'd0, 1'b0, "R9");
        cyc(1'b1, 1'b0, 3'd1, 16'h7777, 1'b1, 3'd1, 1'b0, 3'd1, 1'b0, "R9");
        cyc(1'b1, 1'b1, 3'd1, 16'h0055, 1'b1, 3'd1, 1'b0, 3'd1, 1'b1, "R9");
        cyc(1'b1, 1'b1, 3'd5, 16'h0066, 1'b1, 3'd1, 1'b0, 3'd5, 1'b1, "R9");
        cyc(1'b1, 1'b0, 3'd2, 16'h4242, 1'b1, 3'd1, 1'b0, 3'd2, 1'b0, "R9");
        rd_pair(3'd1, 1'b0, 3'd2, 1'b0, "R9");

        // R1: reset in mid-run clears contents written above
        do_reset();
        for (int i = 0; i < 8; i += 2) rd_pair(3'(i), 1'b0, 3'(i + 1), 1'b1, "R1");
        rd_pair(3'd0, 1'b0, 3'd0, 1'b0, "R1");

        @(negedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule